// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides, cycle by cycle, who owns a shared bus: the CPU or one of two DMA channels. Each channel raises a request and states whether it runs in burst mode (it keeps the bus for its whole transfer) or cycle-steal mode (it takes the bus for one transfer unit at a time). The channel logic pulses a unit-done strobe at the end of each transfer unit. Together with that strobe, on the last unit, it raises a finished strobe. The arbiter turns these inputs into a registered one-hot grant and a flag that tells whether a DMA channel holds the bus.

Ownership changes only at transfer-unit boundaries or while the CPU owns the bus. A higher-ranked channel can take the bus from a bursting channel at that channel's next unit boundary. If the preempting channel steals cycles, the bus stays with DMA and the two channels alternate unit by unit. The CPU does not regain the bus while any burst transfer is unfinished. Priority is either fixed (channel 0 first) or round-robin. The choice is taken from a select input only while the CPU owns the bus.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While rst_n is low, grant_o is 3'b001 (CPU) and dma_hold_o is 0, and both take these values at once when rst_n falls.
- R2: grant_o is always one-hot. Bit 0 is the CPU, bit 1 is channel 0 and bit 2 is channel 1. dma_hold_o is 1 exactly when bit 0 is 0.
- R3: While the CPU owns the bus, the grant goes at the next edge to the highest-ranked requesting channel, and stays with the CPU if no channel requests. A channel keeps the grant until its own unit_done_i bit is high at an edge. A unit_done_i bit from a channel that does not own the bus changes nothing.
- R4: In fixed priority (prio_rr_i = 0), channel 0 outranks channel 1. A channel 0 request made while channel 1 bursts takes the bus at the edge where channel 1 completes its current unit.
- R5: A burst-mode owner keeps the bus across its unit boundaries as long as no higher-ranked candidate exists. When it finishes (unit_done_i and xfer_done_i both high for that channel), an unfinished burst on the other channel resumes at that edge.
- R6: When a cycle-steal owner (chan_burst_i bit = 0 when it was granted) completes a unit while the other channel has an unfinished burst, the bus passes straight to the bursting channel, with no CPU cycle in between. The grants then alternate between the two channels.
- R7: A burst is unfinished from the edge that grants the channel in burst mode (chan_burst_i bit = 1) until that channel's finishing edge. While any burst is unfinished, grant_o bit 0 stays 0.
- R8: When a cycle-steal owner completes a unit and no burst is unfinished, the CPU owns the bus for at least the next cycle, even if a channel still requests.
- R9: In round-robin priority (prio_rr_i = 1), the channel whose unit completes at an edge ranks lowest in the choice made at that edge. From CPU ownership, the channel that completed the most recent owned unit ranks lowest.
- R10: The priority scheme follows prio_rr_i only while the CPU owns the bus. Changes of prio_rr_i while a channel owns the bus have no effect until the CPU owns it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prio_rr_i | input | 1 | Priority scheme: 0 fixed, 1 round-robin |
| chan_req_i | input | 2 | Transfer request per channel |
| chan_burst_i | input | 2 | Per-channel mode: 1 burst, 0 cycle steal |
| unit_done_i | input | 2 | Per-channel pulse at the end of a transfer unit |
| xfer_done_i | input | 2 | Per-channel pulse, with unit_done_i, on the final unit |
| grant_o | output | 3 | One-hot owner: bit 0 CPU, bit 1 channel 0, bit 2 channel 1 |
| dma_hold_o | output | 1 | A DMA channel owns the bus |

## Verification
A wrong record of unfinished bursts shows at the ports within one unit boundary. The grant either returns to the CPU while a burst is still open, or stays with a channel after its finished strobe. A stale last-served index or a wrong latched priority scheme makes the wrong channel win the next contested boundary. The sequences used therefore run both channels in burst at once under each scheme. They also change the scheme select during DMA ownership and then check the very next contested choice.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int NCH = 2;
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GW  = NCH + 1;
endpackage

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
  parameter int NCH = dmaarb_pkg::NCH,
  parameter int CW  = dmaarb_pkg::CW
) (
  input  logic [NCH-1:0] cand_i,
  input  logic           rr_en_i,
  input  logic [CW-1:0]  last_i,
  output logic           found_o,
  output logic [CW-1:0]  pick_o
);
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = 0; k < NCH; k++) begin
      int idx;
      idx = rr_en_i ? ((int'(last_i) + 1 + k) % NCH) : k;
      if (!found_o && cand_i[idx]) begin
        found_o = 1'b1;
        pick_o  = CW'(idx);
      end
    end
  end
endmodule

// File: rtl/dmaarb_burst_trk.sv
module dmaarb_burst_trk #(
  parameter int NCH = dmaarb_pkg::NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] act_o,
  output logic [NCH-1:0] kept_o
);
  logic [NCH-1:0] act_q, act_n;

  always_comb begin
    kept_o = act_q & ~clr_i;
    act_n  = kept_o | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_n;
  end

  assign act_o = act_q;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dmaarb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prio_rr_i,
  input  logic [NCH-1:0] chan_req_i,
  input  logic [NCH-1:0] chan_burst_i,
  input  logic [NCH-1:0] unit_done_i,
  input  logic [NCH-1:0] xfer_done_i,
  output logic [GW-1:0]  grant_o,
  output logic           dma_hold_o
);
  logic [GW-1:0]  grant_q, grant_n;
  logic           rr_q;
  logic [CW-1:0]  last_q, last_eff;
  logic [NCH-1:0] own_vec, fin_vec, cs_own, cand, set_vec, burst_q, kept;
  logic [CW-1:0]  own_idx, pick;
  logic           owner_cpu, ud_own, ev, cs_back, found, eff_rr;

  assign owner_cpu = grant_q[0];
  assign own_vec   = grant_q[GW-1:1];
  assign ud_own    = |(unit_done_i & own_vec);
  assign fin_vec   = own_vec & unit_done_i & xfer_done_i;
  assign cs_own    = own_vec & ~burst_q;
  assign ev        = owner_cpu | ud_own;
  assign eff_rr    = owner_cpu ? prio_rr_i : rr_q;

  always_comb begin
    own_idx = '0;
    for (int k = 0; k < NCH; k++)
      if (own_vec[k]) own_idx = CW'(k);
  end

  assign last_eff = ud_own ? own_idx : last_q;

  dmaarb_burst_trk #(.NCH(NCH)) trk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (fin_vec),
    .act_o (burst_q),
    .kept_o(kept)
  );

  // cycle-steal owner must yield; a finishing owner drops out
  assign cand    = (chan_req_i | kept) & ~fin_vec & ~cs_own;
  assign cs_back = (|cs_own) & ~(|kept);

  dmaarb_pick #(.NCH(NCH), .CW(CW)) pick_i (
    .cand_i (cand),
    .rr_en_i(eff_rr),
    .last_i (last_eff),
    .found_o(found),
    .pick_o (pick)
  );

  always_comb begin
    grant_n = grant_q;
    set_vec = '0;
    if (ev) begin
      if (cs_back || !found) begin
        grant_n = GW'(1);
      end else begin
        grant_n = GW'(2) << pick;
        set_vec = (NCH'(1) << pick) & chan_burst_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= GW'(1);
      rr_q    <= 1'b0;
      last_q  <= '0;
    end else begin
      grant_q <= grant_n;
      if (owner_cpu) rr_q   <= prio_rr_i;
      if (ud_own)    last_q <= own_idx;
    end
  end

  assign grant_o    = grant_q;
  assign dma_hold_o = ~grant_q[0];

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_q) == 1);

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|burst_q) |-> !grant_q[0]);

  // R3
  owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_q[0] && !(|(unit_done_i & grant_q[GW-1:1]))) |=> $stable(grant_q));

  // R8
  cs_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(unit_done_i & grant_q[GW-1:1] & ~burst_q)) && !(|(burst_q & ~fin_vec)))
      |=> grant_q[0]);

  // R10
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_q[0] |=> $stable(rr_q));
endmodule

// File: tb/dma_bus_arbiter_tb.sv
`timescale 1ns/1ps
module dma_bus_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       prio_rr;
  logic [1:0] req, burst, ud, xd;
  logic [2:0] grant;
  logic       hold;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  dma_bus_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .prio_rr_i(prio_rr),
    .chan_req_i(req), .chan_burst_i(burst),
    .unit_done_i(ud), .xfer_done_i(xd),
    .grant_o(grant), .dma_hold_o(hold)
  );

  // {tag, rr, req, burst, ud, xd, expected grant}
  localparam int NV = 39;
  localparam logic [15:0] VEC [NV] = '{
    {4'd3, 1'b0, 2'b10, 2'b10, 2'b00, 2'b00, 3'b100}, // R3 ch1 burst from idle
    {4'd3, 1'b0, 2'b10, 2'b10, 2'b00, 2'b00, 3'b100},
    {4'd3, 1'b0, 2'b11, 2'b10, 2'b00, 2'b00, 3'b100}, // R3 no boundary yet
    {4'd4, 1'b0, 2'b11, 2'b10, 2'b10, 2'b00, 3'b010}, // R4 preempt
    {4'd6, 1'b0, 2'b11, 2'b10, 2'b01, 2'b00, 3'b100}, // R6 interleave
    {4'd6, 1'b0, 2'b11, 2'b10, 2'b10, 2'b00, 3'b010},
    {4'd6, 1'b0, 2'b10, 2'b10, 2'b01, 2'b00, 3'b100},
    {4'd7, 1'b0, 2'b10, 2'b10, 2'b10, 2'b10, 3'b001}, // R7 burst done
    {4'd3, 1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 3'b010},
    {4'd8, 1'b0, 2'b01, 2'b00, 2'b01, 2'b00, 3'b001}, // R8 cpu slot
    {4'd8, 1'b0, 2'b01, 2'b00, 2'b00, 2'b00, 3'b010},
    {4'd8, 1'b0, 2'b00, 2'b00, 2'b01, 2'b01, 3'b001},
    {4'd3, 1'b0, 2'b10, 2'b11, 2'b00, 2'b00, 3'b100},
    {4'd3, 1'b0, 2'b11, 2'b11, 2'b00, 2'b00, 3'b100},
    {4'd4, 1'b0, 2'b11, 2'b11, 2'b10, 2'b00, 3'b010}, // R4 burst preempts burst
    {4'd5, 1'b0, 2'b11, 2'b11, 2'b01, 2'b00, 3'b010}, // R5 keeps bus
    {4'd5, 1'b0, 2'b11, 2'b11, 2'b01, 2'b01, 3'b100}, // R5 resume ch1
    {4'd5, 1'b0, 2'b10, 2'b11, 2'b10, 2'b10, 3'b001},
    {4'd3, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00, 3'b001}, // R3 strobes at cpu
    {4'd3, 1'b0, 2'b10, 2'b10, 2'b00, 2'b00, 3'b100},
    {4'd3, 1'b0, 2'b10, 2'b10, 2'b01, 2'b00, 3'b100}, // R3 non-owner strobe
    {4'd7, 1'b0, 2'b00, 2'b10, 2'b10, 2'b10, 3'b001},
    {4'd10,1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 3'b001},
    {4'd9, 1'b1, 2'b11, 2'b11, 2'b00, 2'b00, 3'b010}, // R9 last was ch1
    {4'd9, 1'b1, 2'b11, 2'b11, 2'b01, 2'b00, 3'b100},
    {4'd9, 1'b1, 2'b11, 2'b11, 2'b10, 2'b00, 3'b010},
    {4'd9, 1'b1, 2'b10, 2'b11, 2'b01, 2'b01, 3'b100},
    {4'd9, 1'b1, 2'b00, 2'b11, 2'b10, 2'b10, 3'b001},
    {4'd10,1'b1, 2'b10, 2'b10, 2'b00, 2'b00, 3'b100}, // R10 rr latched
    {4'd10,1'b0, 2'b11, 2'b11, 2'b00, 2'b00, 3'b100},
    {4'd10,1'b0, 2'b11, 2'b11, 2'b10, 2'b00, 3'b010},
    {4'd10,1'b0, 2'b11, 2'b11, 2'b01, 2'b00, 3'b100}, // R10 still rr
    {4'd7, 1'b0, 2'b01, 2'b11, 2'b10, 2'b10, 3'b010},
    {4'd7, 1'b0, 2'b00, 2'b11, 2'b01, 2'b01, 3'b001},
    {4'd10,1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 3'b001},
    {4'd10,1'b0, 2'b11, 2'b11, 2'b00, 2'b00, 3'b010}, // R10 fixed now
    {4'd4, 1'b0, 2'b11, 2'b11, 2'b01, 2'b00, 3'b010},
    {4'd5, 1'b0, 2'b10, 2'b11, 2'b01, 2'b01, 3'b100},
    {4'd5, 1'b0, 2'b00, 2'b11, 2'b10, 2'b10, 3'b001}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; prio_rr = 1'b0; req = '0; burst = '0; ud = '0; xd = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 grant in reset", {1'b0, grant}, 4'b0001);
    check("R1 hold in reset", {3'b0, hold}, 4'b0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      prio_rr = v[11]; req = v[10:9]; burst = v[8:7]; ud = v[6:5]; xd = v[4:3];
      @(negedge clk);
      check($sformatf("R%0d vec %0d grant", v[15:12], i), {1'b0, grant}, {1'b0, v[2:0]});
      // R2 hold flag and one-hot
      check($sformatf("R2 vec %0d hold", i), {3'b0, hold}, {3'b0, (v[2:0] != 3'b001)});
      check($sformatf("R2 vec %0d onehot", i), {3'b0, $onehot(grant)}, 4'b0001);
    end
    // R1 asynchronous reset in the middle of a burst
    prio_rr = 1'b0; req = 2'b10; burst = 2'b10; ud = '0; xd = '0;
    @(negedge clk);
    check("R1 pre-reset grant", {1'b0, grant}, 4'b0100);
    #2 rst_n = 1'b0;
    #1 check("R1 async grant", {1'b0, grant}, 4'b0001);
    check("R1 async hold", {3'b0, hold}, 4'b0000);
    req = '0; burst = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 burst record cleared by reset: cycle-steal unit returns to cpu
    req = 2'b01;
    @(negedge clk);
    check("R7 post-reset grant", {1'b0, grant}, 4'b0010);
    ud = 2'b01;
    @(negedge clk);
    ud = '0; req = '0;
    check("R8 post-reset cpu slot", {1'b0, grant}, 4'b0001);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule